// File: doc/BRIEF.md
# Bidirectional Parallel/Serial Bus Register

This block is an eight-stage storage register placed between two 8-bit buses, called A and B. It can take a word from one bus and present it on the other, in either direction. It can also shift a serial bit stream into the stages and show the result on either bus, or shift a loaded word out one bit at a time. When it is idle it keeps its word by feeding each stage back into itself. Each bus is modelled as three signals: an input vector, an output vector and an output enable. Only the A side has an enable of its own, so several of these registers can share one A bus.

All logic runs on one system clock. The external shift/load clock is an ordinary input. It passes through a synchroniser, and the block acts on each rising edge it detects. Five controls select the operation: the external clock, the A-side enable, parallel versus serial operation, the transfer direction, and whether a parallel load waits for an external clock edge or runs freely.

Top module: `busShiftReg`

## Requirements
- R1: While `rstN` is low, every stage clears to 0 on the system clock, and `aOe` and `bOe` read 0. The reset value appears on `aOut`, `bOut` and `serOut`.
- R2: With `parSel` low (serial), each detected external clock rise moves stage k into stage k+1 and loads `serIn` into stage 1. Stage 1 is bit 0 of `aOut`/`bOut` and stage 8 is bit 7. `asyncSel` has no effect in this mode: with no external edge, the stages keep their value whatever `asyncSel` is.
- R3: With `parSel` high and `asyncSel` low, the source bus is captured only on a detected external clock rise. Without a rise, the stages keep their value.
- R4: With `parSel` high and `asyncSel` high, the source bus is captured on every system clock edge, with no external edge needed. The captured value is visible one system clock later.
- R5: With `dirAtoB` high, the source bus is A (gated by `aEn`). With `dirAtoB` low, the source bus is B.
- R6: `aOe` is high exactly when, on the previous system clock edge, `dirAtoB` was low and `aEn` was high. This holds in both serial and parallel mode.
- R7: In parallel mode with `dirAtoB` high and `aEn` low, the stages keep their value. External clock edges, free-running loads and changes on `aIn` do not alter it.
- R8: `bOe` equals the value `dirAtoB` had on the previous system clock edge. `aEn` has no influence on it.
- R9: A rise of `extClk` changes the stages on the third system clock edge after `extClk` is first sampled high. An `extClk` held high for many cycles causes exactly one update.
- R10: `serOut` always shows stage 8. So a word loaded in parallel leaves in the order bit 7 first, then bit 6, and so on, during successive serial shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| extClk | input | 1 | External shift/load clock, asynchronous to `clk` |
| aEn | input | 1 | A-side enable for capture and drive |
| parSel | input | 1 | 1 = parallel operation, 0 = serial |
| dirAtoB | input | 1 | 1 = A is source and B is driven, 0 = the reverse |
| asyncSel | input | 1 | 1 = free-running parallel load, 0 = load on external edge |
| serIn | input | 1 | Serial data into stage 1 |
| aIn | input | 8 | A bus as seen by the block |
| aOut | output | 8 | Register contents toward the A bus |
| aOe | output | 1 | A bus output enable |
| bIn | input | 8 | B bus as seen by the block |
| bOut | output | 8 | Register contents toward the B bus |
| bOe | output | 1 | B bus output enable |
| serOut | output | 1 | Stage 8 value |

## Verification
An edge-triggered update reaches the stages three system clocks after `extClk` is first sampled high. The bench raises `extClk` at a falling edge of `clk` and holds it for four cycles before it compares. A free-running load and a change to an output enable each take one system clock. In those cases the bench changes the controls at a falling edge and compares at the next falling edge. Every expected value comes from a model of the stages that the driver updates. The monitor checks it against the outputs only at those settled falling-edge points.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef struct packed {
    logic shiftEn;
    logic loadA;
    logic loadB;
    logic aDrive;
    logic bDrive;
  } bsrStrobe_t;
endpackage

// File: rtl/bsr_ctrl.sv
module bsr_ctrl
  import bsr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       extClk,
  input  logic       parSel,
  input  logic       asyncSel,
  input  logic       dirAtoB,
  input  logic       aEn,
  output bsrStrobe_t strobe
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] syncQ;
  logic         lastQ;
  logic         extRise;
  logic         loadFire;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= extClk;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[TOP-1:0], extClk};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) lastQ <= 1'b0;
    else       lastQ <= syncQ[TOP];
  end

  assign extRise  = syncQ[TOP] & ~lastQ;
  assign loadFire = asyncSel | extRise;

  always_comb begin
    strobe         = '0;
    strobe.aDrive  = ~dirAtoB & aEn;
    strobe.bDrive  = dirAtoB;
    if (!parSel) begin
      strobe.shiftEn = extRise;
    end else if (dirAtoB) begin
      strobe.loadA = loadFire & aEn;
    end else begin
      strobe.loadB = loadFire;
    end
  end

  // R9
  single_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    extRise |=> !extRise);
endmodule

// File: rtl/bsr_datapath.sv
module bsr_datapath
  import bsr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  bsrStrobe_t       strobe,
  input  logic             serIn,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] stageQ,
  output logic             aOe,
  output logic             bOe,
  output logic             serOut
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] stageD;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      logic fromLeft;
      if (i == 0) begin : g_first
        assign fromLeft = serIn;
      end else begin : g_rest
        assign fromLeft = stageQ[i-1];
      end
      assign stageD[i] = strobe.shiftEn ? fromLeft :
                         strobe.loadA   ? aIn[i]   :
                         strobe.loadB   ? bIn[i]   : stageQ[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageQ <= '0;
      aOe    <= 1'b0;
      bOe    <= 1'b0;
    end else begin
      stageQ <= stageD;
      aOe    <= strobe.aDrive;
      bOe    <= strobe.bDrive;
    end
  end

  assign serOut = stageQ[MSB];

  // R2
  shift_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |=> (stageQ[0] == $past(serIn)) &&
                       (stageQ[MSB:1] == $past(stageQ[MSB-1:0])));
  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.shiftEn || strobe.loadA || strobe.loadB) |=> $stable(stageQ));
endmodule

// File: rtl/busShiftReg.sv
module busShiftReg
  import bsr_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extClk,
  input  logic             aEn,
  input  logic             parSel,
  input  logic             dirAtoB,
  input  logic             asyncSel,
  input  logic             serIn,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOe,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] bOut,
  output logic             bOe,
  output logic             serOut
);
  bsrStrobe_t       strobe;
  logic [WIDTH-1:0] stageQ;

  bsr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .extClk(extClk), .parSel(parSel),
    .asyncSel(asyncSel), .dirAtoB(dirAtoB), .aEn(aEn), .strobe(strobe)
  );

  bsr_datapath #(.WIDTH(WIDTH)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .serIn(serIn),
    .aIn(aIn), .bIn(bIn), .stageQ(stageQ), .aOe(aOe), .bOe(bOe),
    .serOut(serOut)
  );

  assign aOut = stageQ;
  assign bOut = stageQ;

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (stageQ == '0) && !aOe && !bOe);
  // R6
  a_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> aOe == ($past(!dirAtoB) && $past(aEn)));
  // R8
  b_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> bOe == $past(dirAtoB));
endmodule

// File: tb/test_busShiftReg.sv
module test_busShiftReg;
  typedef struct {
    logic [7:0] data;
    logic       aOeExp;
    logic       bOeExp;
    string      req;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extClk = 1'b0, aEn = 1'b0, parSel = 1'b1, dirAtoB = 1'b1;
  logic asyncSel = 1'b0, serIn = 1'b0;
  logic [7:0] aIn = '0, bIn = '0;
  logic [7:0] aOut, bOut;
  logic aOe, bOe, serOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model = '0;
  expItem_t scoreQ[$];
  event sampleEv;

  always #10 clk = ~clk;

  busShiftReg i_busShiftReg (
    .clk(clk), .rstN(rstN), .extClk(extClk), .aEn(aEn), .parSel(parSel),
    .dirAtoB(dirAtoB), .asyncSel(asyncSel), .serIn(serIn), .aIn(aIn),
    .aOut(aOut), .aOe(aOe), .bIn(bIn), .bOut(bOut), .bOe(bOe),
    .serOut(serOut)
  );

  task automatic expectNow(input string req, input logic oeA, input logic oeB);
    expItem_t it;
    it.data = model; it.aOeExp = oeA; it.bOeExp = oeB; it.req = req;
    scoreQ.push_back(it);
    ->sampleEv;
    #1;
  endtask

  task automatic expectStd(input string req);
    expectNow(req, !dirAtoB && aEn, dirAtoB);
  endtask

  task automatic pulseExt();
    @(negedge clk) extClk = 1'b1;
    repeat (4) @(negedge clk);
    extClk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic stepCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(sampleEv);
      while (scoreQ.size() > 0) begin
        expItem_t it;
        it = scoreQ.pop_front();
        checks++;
        if (aOut !== it.data || bOut !== it.data || serOut !== it.data[7] ||
            aOe !== it.aOeExp || bOe !== it.bOeExp) begin
          errors++;
          $display("FAIL %s: actual a=%h b=%h ser=%b aOe=%b bOe=%b expected data=%h ser=%b aOe=%b bOe=%b",
                   it.req, aOut, bOut, serOut, aOe, bOe, it.data, it.data[7],
                   it.aOeExp, it.bOeExp);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    // R1: reset with B drive requested and A enabled
    aEn = 1'b1; aIn = 8'hFF; asyncSel = 1'b1;
    stepCycles(4);
    expectNow("R1", 1'b0, 1'b0);
    @(negedge clk) rstN = 1'b1; aEn = 1'b0; asyncSel = 1'b0;
    stepCycles(1);
    // R8: B enable follows direction alone; R7 hold
    expectStd("R8");

    // R3: no load without an external edge
    aEn = 1'b1; aIn = 8'hA5;
    stepCycles(6);
    expectStd("R3");
    pulseExt();
    model = 8'hA5;
    expectStd("R3");

    // R7: recirculation with A disabled
    aEn = 1'b0; aIn = 8'h3C;
    pulseExt();
    expectStd("R7");
    asyncSel = 1'b1;
    stepCycles(3);
    expectStd("R7");
    asyncSel = 1'b0;

    // R5/R6: B to A, A enable on
    dirAtoB = 1'b0; aEn = 1'b1; bIn = 8'h5A;
    stepCycles(1);
    expectStd("R6");
    pulseExt();
    model = 8'h5A;
    expectStd("R5");
    aEn = 1'b0;
    stepCycles(1);
    // R6 and R8: aEn off drops A drive, B stays off
    expectStd("R6");

    // R4: free-running load from B
    asyncSel = 1'b1; bIn = 8'h81;
    stepCycles(1);
    model = 8'h81;
    expectStd("R4");
    bIn = 8'h7E;
    stepCycles(1);
    model = 8'h7E;
    expectStd("R4");

    // R2: serial shift, asyncSel ignored
    parSel = 1'b0; dirAtoB = 1'b1; serIn = 1'b1;
    stepCycles(5);
    expectStd("R2");
    pulseExt();
    model = {model[6:0], 1'b1};
    expectStd("R2");
    serIn = 1'b0;
    pulseExt();
    model = {model[6:0], 1'b0};
    expectStd("R2");
    asyncSel = 1'b0;

    // R9: extClk held high gives one update, on the third edge
    serIn = 1'b1;
    @(negedge clk) extClk = 1'b1;
    stepCycles(2);
    expectStd("R9");
    stepCycles(1);
    model = {model[6:0], 1'b1};
    expectStd("R9");
    stepCycles(10);
    expectStd("R9");
    extClk = 1'b0;
    stepCycles(4);

    // R10: parallel load then shift out MSB first
    parSel = 1'b1; aEn = 1'b1; aIn = 8'hC3;
    pulseExt();
    model = 8'hC3;
    expectStd("R10");
    parSel = 1'b0; serIn = 1'b0;
    for (int k = 0; k < 8; k++) begin
      pulseExt();
      model = {model[6:0], 1'b0};
      expectStd("R10");
    end

    done = 1;
    stepCycles(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule